// File: doc/BRIEF.md
# Three-State Up/Down Ring Sequencer

The block is a small synchronous state machine that walks a ring of three positions. When its enable input is high, an up request moves it one position forward around the ring and a down request moves it one position back. With enable low, or with no request, it stays where it is. Two status outputs are combinational functions of the current position and the inputs, so they are valid in the same cycle as the hold decision. The first output says the machine will not move on the coming edge. The second says it is holding in its third position.

The position is kept in a two-bit register. The fourth code of that register is not part of the ring. If the register ever holds that code, the next clock returns it to the start position whatever the inputs are, and both status outputs stay low. The register powers up holding the unused code, so this recovery also happens on the first clock after configuration. A synchronous active-high reset forces the start position.

Top module: `tri_ring_seq`

## Requirements
- R1: pos_o encodes the ring positions as 0 (start), 1 and 2. The code 3 is the unused code.
- R2: With step_en=1 and step_up=1, the next edge moves pos_o forward: 0 to 1, 1 to 2, 2 to 0.
- R3: With step_en=1, step_dn=1 and step_up=0, the next edge moves pos_o backward: 0 to 2, 2 to 1, 1 to 0.
- R4: When step_up and step_dn are both 1 with step_en=1, the forward move is taken.
- R5: In positions 0, 1 and 2, when step_en=0 or neither request is high, pos_o keeps its value across the edge and idle_o is 1 in that same cycle. Otherwise idle_o is 0.
- R6: idle_last_o is 1 exactly when idle_o is 1 and pos_o is 2.
- R7: In code 3, the next edge loads position 0 for any input values, and idle_o and idle_last_o are both 0.
- R8: Before any reset, the position register holds code 3.
- R9: rst=1 at an edge loads position 0, taking priority over all requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_up | input | 1 | Forward request |
| step_dn | input | 1 | Backward request |
| step_en | input | 1 | Qualifies both requests |
| pos_o | output | 2 | Current ring position |
| idle_o | output | 1 | Machine holds on the coming edge |
| idle_last_o | output | 1 | Machine holds in position 2 |

## Verification
The unused code cannot be reached from the ports once the machine is running. A reset clears it, and the ring never produces it. The only way to reach it is the power-up value. The bench therefore leaves reset low at time zero and applies a backward request. It checks that both flags are low and that the first edge lands on position 0 and not on the backward neighbour. After that, every request combination is applied from each ring position, and each position is reached by a reset followed by counted forward steps.

// File: rtl/tri_ring_pkg.sv
package tri_ring_pkg;
  localparam int POS_W = 2;

  typedef enum logic [POS_W-1:0] {
    POS_START = 2'd0,
    POS_MID   = 2'd1,
    POS_LAST  = 2'd2,
    POS_BAD   = 2'd3
  } pos_t;
endpackage

// File: rtl/tri_ring_next.sv
module tri_ring_next
  import tri_ring_pkg::*;
(
  input  pos_t cur_i,
  input  logic up_i,
  input  logic dn_i,
  input  logic en_i,
  output pos_t nxt_o,
  output logic hold_o
);
  logic go_fwd;
  logic go_bwd;

  // forward wins when both requests are present
  assign go_fwd = en_i & up_i;
  assign go_bwd = en_i & dn_i & ~up_i;

  always_comb begin
    nxt_o = cur_i;
    unique case (cur_i)
      POS_START: if (go_fwd) nxt_o = POS_MID;   else if (go_bwd) nxt_o = POS_LAST;
      POS_MID:   if (go_fwd) nxt_o = POS_LAST;  else if (go_bwd) nxt_o = POS_START;
      POS_LAST:  if (go_fwd) nxt_o = POS_START; else if (go_bwd) nxt_o = POS_MID;
      default:   nxt_o = POS_START;
    endcase
  end

  assign hold_o = (cur_i != POS_BAD) & ~(go_fwd | go_bwd);
endmodule

// File: rtl/tri_ring_flags.sv
module tri_ring_flags
  import tri_ring_pkg::*;
(
  input  pos_t cur_i,
  input  logic hold_i,
  output logic idle_o,
  output logic idle_last_o
);
  assign idle_o      = hold_i;
  assign idle_last_o = hold_i & (cur_i == POS_LAST);
endmodule

// File: rtl/tri_ring_reg.sv
module tri_ring_reg
  import tri_ring_pkg::*;
#(
  parameter pos_t POWER_UP = POS_BAD
) (
  input  logic clk,
  input  logic rst,
  input  pos_t d_i,
  output pos_t q_o
);
  pos_t q_r = POWER_UP;

  always_ff @(posedge clk) begin
    if (rst) q_r <= POS_START;
    else     q_r <= d_i;
  end

  assign q_o = q_r;
endmodule

// File: rtl/tri_ring_seq.sv
module tri_ring_seq
  import tri_ring_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             step_en,
  output logic [POS_W-1:0] pos_o,
  output logic             idle_o,
  output logic             idle_last_o
);
  pos_t cur;
  pos_t nxt;
  logic hold;

  tri_ring_reg #(.POWER_UP(POS_BAD)) u_reg (
    .clk (clk),
    .rst (rst),
    .d_i (nxt),
    .q_o (cur)
  );

  tri_ring_next u_next (
    .cur_i  (cur),
    .up_i   (step_up),
    .dn_i   (step_dn),
    .en_i   (step_en),
    .nxt_o  (nxt),
    .hold_o (hold)
  );

  tri_ring_flags u_flags (
    .cur_i       (cur),
    .hold_i      (hold),
    .idle_o      (idle_o),
    .idle_last_o (idle_last_o)
  );

  assign pos_o = cur;
endmodule

// File: rtl/tri_ring_seq_chk.sv
module tri_ring_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       step_up,
  input logic       step_dn,
  input logic       step_en,
  input logic [1:0] pos_o,
  input logic       idle_o,
  input logic       idle_last_o
);
  a_r2_forward: assert property (@(posedge clk) disable iff (rst)
    (step_en && step_up && pos_o != 2'd3) |=> (pos_o == ($past(pos_o) == 2'd2 ? 2'd0 : $past(pos_o) + 2'd1)));

  a_r3_backward: assert property (@(posedge clk) disable iff (rst)
    (step_en && step_dn && !step_up && pos_o != 2'd3) |=> (pos_o == ($past(pos_o) == 2'd0 ? 2'd2 : $past(pos_o) - 2'd1)));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!(step_en && (step_up || step_dn)) && pos_o != 2'd3) |-> idle_o ##1 $stable(pos_o));

  a_r6_last: assert property (@(posedge clk) disable iff (rst)
    idle_last_o |-> (idle_o && pos_o == 2'd2));

  a_r7_recover: assert property (@(posedge clk) disable iff (rst)
    (pos_o == 2'd3) |-> (!idle_o && !idle_last_o) ##1 (pos_o == 2'd0));

  a_r9_reset: assert property (@(posedge clk)
    rst |=> (pos_o == 2'd0));
endmodule

bind tri_ring_seq tri_ring_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .step_up     (step_up),
  .step_dn     (step_dn),
  .step_en     (step_en),
  .pos_o       (pos_o),
  .idle_o      (idle_o),
  .idle_last_o (idle_last_o)
);

// File: tb/tri_ring_seq_bench.sv
module tri_ring_seq_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b0;
  logic up  = 1'b0;
  logic dn  = 1'b1;
  logic en  = 1'b1;
  logic [1:0] pos;
  logic idle, idle_last;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  tri_ring_seq u_tri_ring_seq (
    .clk (clk), .rst (rst), .step_up (up), .step_dn (dn), .step_en (en),
    .pos_o (pos), .idle_o (idle), .idle_last_o (idle_last)
  );

  // stimulus {up, dn, en} and expected action: 0 hold, 1 forward, 2 backward
  localparam logic [4:0] VEC [8] = '{
    5'b000_00, 5'b100_00, 5'b010_00, 5'b110_00,
    5'b001_00, 5'b101_01, 5'b011_10, 5'b111_01
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_to(input int s);
    @(negedge clk);
    rst = 1'b1; en = 1'b0; up = 1'b0; dn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset to start", pos, 0);
    en = 1'b1; up = 1'b1;
    repeat (s) @(negedge clk);
    en = 1'b0; up = 1'b0;
    chk("R2 forward walk", pos, s);
  endtask

  initial begin
    // R8 and R7: power-up code, flags low, recovery ignores a backward request
    #1;
    chk("R8 power-up code", pos, 3);
    chk("R7 idle low in code 3", idle, 0);
    chk("R7 idle_last low in code 3", idle_last, 0);
    @(posedge clk); #1;
    chk("R7 recovery to start", pos, 0);

    for (int s = 0; s < 3; s++) begin
      for (int v = 0; v < 8; v++) begin
        int exp_pos;
        string tag;
        go_to(s);
        {up, dn, en} = VEC[v][4:2];
        case (VEC[v][1:0])
          2'd1:    begin exp_pos = (s + 1) % 3; tag = (up && dn) ? "R4 up wins" : "R2 forward"; end
          2'd2:    begin exp_pos = (s + 2) % 3; tag = "R3 backward"; end
          default: begin exp_pos = s;           tag = "R5 hold"; end
        endcase
        #1;
        chk("R5 idle flag", idle, VEC[v][1:0] == 2'd0);
        chk("R6 idle_last flag", idle_last, (VEC[v][1:0] == 2'd0) && s == 2);
        @(posedge clk); #1;
        chk(tag, pos, exp_pos);
        chk("R1 legal code", pos < 3, 1);
      end
    end

    // R9: reset beats a forward request
    go_to(1);
    @(negedge clk);
    rst = 1'b1; en = 1'b1; up = 1'b1;
    @(posedge clk); #1;
    chk("R9 reset priority", pos, 0);
    rst = 1'b0; en = 1'b0; up = 1'b0;

    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule